// File: doc/BRIEF.md
# Priority-Vectored Interrupt Arbiter

This block decides, at each instruction boundary of a workspace-based minicomputer core, whether the sequencer must take an interrupt trap, and which one. Sixteen maskable request lines (line n is level n, level 0 the most urgent) compete with two sources that the mask cannot stop: a non-maskable request ranked above every level, and an illegal-opcode trap ranked at level 2. A maskable request is granted only if its level number does not exceed the 4-bit mask taken from status bits 12..15.

The request lines are captured into a pending snapshot on every cycle of the sampling window that the core opens during prefetch. Outside that window the snapshot holds. When the core raises its boundary strobe, the block grants the winning source. It presents the workspace-pointer and program-counter vector addresses and the mask value to load. One cycle later it pulses a request for the core to save the old WP, PC and ST into registers 13, 14 and 15 of the new workspace. After a grant, every source is held off until the core reports that the first handler instruction has been processed.

Top module: `irq_arbiter`

## Requirements
- R1: Among pending maskable requests, the lowest-numbered line wins.
- R2: A maskable level is granted only when its number is less than or equal to `cur_mask`; a pending level above the mask yields no grant.
- R3: `take_trap` is high only in a cycle where `instr_done` is high.
- R4: On a grant, `new_mask` is the level minus one for maskable level 1..15, 0 for level 0, 0 for the non-maskable source and 1 for the illegal-opcode trap.
- R5: Vector addresses: maskable level n gives `vec_wp` = 4n and `vec_pc` = 4n+2; the illegal-opcode trap gives 8 and 10; the non-maskable source gives FFFC and FFFE hex.
- R6: The non-maskable source is granted regardless of the mask and beats every other source; `trap_kind` = 1 for it.
- R7: The illegal-opcode trap (`trap_kind` = 2, `trap_level` = 2) is granted regardless of the mask, beats levels 2..15 and loses to a granted level 0 or 1; maskable grants give `trap_kind` = 0 with `trap_level` = the line number.
- R8: After a grant, `inhibit` is high from the next cycle and no grant occurs until a cycle with `first_done` high has passed; `inhibit` is low in the cycle after that strobe.
- R9: Requests are captured only at clock edges where `sample_en` is high; changes while it is low do not alter the granted source.
- R10: `save_ctx` is high exactly in the cycle after each grant.
- R11: After reset, no request is pending, `inhibit` is low and no grant is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 16 | Maskable request lines, bit n is level n |
| nmi_req | input | 1 | Non-maskable request |
| illop_req | input | 1 | Illegal-opcode trap request |
| cur_mask | input | 4 | Current interrupt mask (status bits 12..15) |
| sample_en | input | 1 | Sampling window open |
| instr_done | input | 1 | Instruction boundary strobe |
| first_done | input | 1 | First handler instruction processed |
| take_trap | output | 1 | Grant: take the trap now |
| trap_kind | output | 2 | 0 maskable, 1 non-maskable, 2 illegal opcode |
| trap_level | output | 4 | Level of the granted source |
| vec_wp | output | 16 | Address of the new workspace pointer |
| vec_pc | output | 16 | Address of the new program counter |
| new_mask | output | 4 | Mask value to load |
| save_ctx | output | 1 | Request to save WP, PC, ST into R13..R15 |
| inhibit | output | 1 | Further interrupts held off |

## Verification
The bench keeps the default build of sixteen levels with 16-bit addresses, small enough that every single request line is tried against every mask value and every pair of lines against every mask. The illegal-opcode source is swept against each line and mask, and the non-maskable source is stacked on mixed patterns, so every ordering between the two unmaskable sources and the mask boundary is reached. Separate sequences hold the inhibit flag across a second boundary and change the lines with the window closed.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
  typedef enum logic [1:0] {
    KIND_MASKABLE = 2'd0,
    KIND_NMI      = 2'd1,
    KIND_ILLOP    = 2'd2
  } trap_kind_e;
endpackage

// File: rtl/irq_sampler.sv
`timescale 1ns/1ps
module irq_sampler #(
  parameter int NUM_LEVELS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_en,
  input  logic [NUM_LEVELS-1:0] irq_req,
  input  logic                  nmi_req,
  input  logic                  illop_req,
  output logic [NUM_LEVELS-1:0] pend_q,
  output logic                  nmi_q,
  output logic                  ill_q
);
  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q[i] <= 1'b0;
      else if (sample_en) pend_q[i] <= irq_req[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
      ill_q <= 1'b0;
    end else if (sample_en) begin
      nmi_q <= nmi_req;
      ill_q <= illop_req;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
  parameter int NUM_LEVELS = 16,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:0] req,
  output logic                  hit,
  output logic [LW-1:0]         lvl
);
  always_comb begin
    hit = 1'b0;
    lvl = '0;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        lvl = LW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_inhibit.sv
`timescale 1ns/1ps
module irq_inhibit (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic first_done,
  output logic inhibit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          inhibit <= 1'b0;
    else if (take)       inhibit <= 1'b1;
    else if (first_done) inhibit <= 1'b0;
  end
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_LEVELS = 16,
  parameter int ADDR_W     = 16,
  parameter int ILL_LEVEL  = 2,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] irq_req,
  input  logic                  nmi_req,
  input  logic                  illop_req,
  input  logic [LW-1:0]         cur_mask,
  input  logic                  sample_en,
  input  logic                  instr_done,
  input  logic                  first_done,
  output logic                  take_trap,
  output logic [1:0]            trap_kind,
  output logic [LW-1:0]         trap_level,
  output logic [ADDR_W-1:0]     vec_wp,
  output logic [ADDR_W-1:0]     vec_pc,
  output logic [LW-1:0]         new_mask,
  output logic                  save_ctx,
  output logic                  inhibit
);
  localparam logic [LW-1:0] ILL_LVL = LW'(ILL_LEVEL);

  // vector slot: word pair at 4*level
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [LW-1:0] l, input logic second);
    return {{(ADDR_W-LW-2){1'b0}}, l, second, 1'b0};
  endfunction

  // mask after entry: one below the level, floor at zero
  function automatic logic [LW-1:0] entry_mask(input logic [LW-1:0] l);
    return (l == '0) ? '0 : l - LW'(1);
  endfunction

  logic [NUM_LEVELS-1:0] pend_q;
  logic                  nmi_q, ill_q;
  logic                  m_hit;
  logic [LW-1:0]         m_lvl;
  logic                  mask_ok, above_ill, cand;
  trap_kind_e            kind;
  logic [LW-1:0]         lvl;
  logic                  save_q;

  irq_sampler #(.NUM_LEVELS(NUM_LEVELS)) u_sampler (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .irq_req(irq_req), .nmi_req(nmi_req), .illop_req(illop_req),
    .pend_q(pend_q), .nmi_q(nmi_q), .ill_q(ill_q)
  );

  irq_prio_enc #(.NUM_LEVELS(NUM_LEVELS)) u_enc (
    .req(pend_q), .hit(m_hit), .lvl(m_lvl)
  );

  assign mask_ok   = m_hit && (m_lvl <= cur_mask);
  assign above_ill = mask_ok && (m_lvl < ILL_LVL);

  always_comb begin
    cand = 1'b1;
    kind = KIND_MASKABLE;
    lvl  = m_lvl;
    if (nmi_q) begin
      kind = KIND_NMI;
      lvl  = '0;
    end else if (above_ill) begin
      kind = KIND_MASKABLE;
    end else if (ill_q) begin
      kind = KIND_ILLOP;
      lvl  = ILL_LVL;
    end else if (!mask_ok) begin
      cand = 1'b0;
    end
  end

  assign take_trap  = instr_done && cand && !inhibit;
  assign trap_kind  = kind;
  assign trap_level = lvl;
  assign vec_wp     = (kind == KIND_NMI) ? {{(ADDR_W-2){1'b1}}, 2'b00} : slot_addr(lvl, 1'b0);
  assign vec_pc     = (kind == KIND_NMI) ? {{(ADDR_W-2){1'b1}}, 2'b10} : slot_addr(lvl, 1'b1);
  assign new_mask   = (kind == KIND_NMI) ? '0 : entry_mask(lvl);

  irq_inhibit u_inh (
    .clk(clk), .rst_n(rst_n), .take(take_trap),
    .first_done(first_done), .inhibit(inhibit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) save_q <= 1'b0;
    else        save_q <= take_trap;
  end
  assign save_ctx = save_q;
endmodule

// File: rtl/irq_arbiter_chk.sv
`timescale 1ns/1ps
module irq_arbiter_chk #(
  parameter int NUM_LEVELS = 16,
  parameter int ADDR_W     = 16,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sample_en,
  input logic                  instr_done,
  input logic                  first_done,
  input logic [LW-1:0]         cur_mask,
  input logic                  take_trap,
  input logic [1:0]            trap_kind,
  input logic [LW-1:0]         trap_level,
  input logic [ADDR_W-1:0]     vec_wp,
  input logic [ADDR_W-1:0]     vec_pc,
  input logic [LW-1:0]         new_mask,
  input logic                  save_ctx,
  input logic                  inhibit,
  input logic [NUM_LEVELS-1:0] pend_q,
  input logic                  nmi_q
);
  assert_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |-> instr_done);

  assert_mask_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_trap && trap_kind == 2'd0) |-> (trap_level <= cur_mask));

  assert_mask_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_trap && trap_kind == 2'd0 && trap_level != '0) |-> (new_mask == trap_level - LW'(1)));

  assert_vec_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |-> (vec_pc == vec_wp + ADDR_W'(2)));

  assert_nmi_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_trap && nmi_q) |-> (trap_kind == 2'd1));

  assert_inhibit_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> inhibit);

  assert_inhibit_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> !take_trap);

  assert_inhibit_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && first_done && !take_trap) |=> !inhibit);

  assert_window_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(pend_q));

  assert_save_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> save_ctx);
endmodule

bind irq_arbiter irq_arbiter_chk #(.NUM_LEVELS(NUM_LEVELS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .instr_done(instr_done),
  .first_done(first_done), .cur_mask(cur_mask), .take_trap(take_trap),
  .trap_kind(trap_kind), .trap_level(trap_level), .vec_wp(vec_wp),
  .vec_pc(vec_pc), .new_mask(new_mask), .save_ctx(save_ctx),
  .inhibit(inhibit), .pend_q(pend_q), .nmi_q(nmi_q)
);

// File: tb/irq_arbiter_tb.sv
`timescale 1ns/1ps
module irq_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_req = '0;
  logic        nmi_req = 1'b0, illop_req = 1'b0;
  logic [3:0]  cur_mask = '0;
  logic        sample_en = 1'b0, instr_done = 1'b0, first_done = 1'b0;
  logic        take_trap, save_ctx, inhibit;
  logic [1:0]  trap_kind;
  logic [3:0]  trap_level, new_mask;
  logic [15:0] vec_wp, vec_pc;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
    .illop_req(illop_req), .cur_mask(cur_mask), .sample_en(sample_en),
    .instr_done(instr_done), .first_done(first_done), .take_trap(take_trap),
    .trap_kind(trap_kind), .trap_level(trap_level), .vec_wp(vec_wp),
    .vec_pc(vec_pc), .new_mask(new_mask), .save_ctx(save_ctx), .inhibit(inhibit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (req=%h nmi=%0b ill=%0b mask=%0d)",
               tag, act, exp, irq_req, nmi_req, illop_req, cur_mask);
    end
  endtask

  // Reference model: kind -1 means no grant
  task automatic model(input logic [15:0] r, input bit n, input bit il, input int m,
                       output int kind, output int lvl, output int wp, output int pc,
                       output int nm);
    int low = 16;
    for (int k = 15; k >= 0; k--) if (r[k]) low = k;
    kind = -1; lvl = 0;
    if (n) kind = 1;
    else if (low < 2 && low <= m) begin kind = 0; lvl = low; end
    else if (il) begin kind = 2; lvl = 2; end
    else if (low < 16 && low <= m) begin kind = 0; lvl = low; end
    if (kind == 1) begin wp = 65532; pc = 65534; nm = 0; end
    else begin wp = lvl * 4; pc = lvl * 4 + 2; nm = (lvl > 0) ? lvl - 1 : 0; end
  endtask

  task automatic run_case(input logic [15:0] r, input bit n, input bit il, input int m);
    int ek, el, ew, ep, em;
    bit et;
    model(r, n, il, m, ek, el, ew, ep, em);
    et = (ek >= 0);
    @(negedge clk);
    irq_req = r; nmi_req = n; illop_req = il; cur_mask = 4'(m);
    sample_en = 1'b1; instr_done = 1'b0; first_done = 1'b0;
    @(posedge clk); @(negedge clk);
    sample_en = 1'b0;
    #1 chk(take_trap == 1'b0, "R3 no grant off boundary", int'(take_trap), 0);
    instr_done = 1'b1;
    #1;
    chk(take_trap == et, "R2/R6/R7 grant", int'(take_trap), int'(et));
    if (et) begin
      chk(int'(trap_kind) == ek, "R6/R7 kind", int'(trap_kind), ek);
      if (ek != 1) chk(int'(trap_level) == el, "R1/R7 level", int'(trap_level), el);
      chk(int'(vec_wp) == ew, "R5 vec_wp", int'(vec_wp), ew);
      chk(int'(vec_pc) == ep, "R5 vec_pc", int'(vec_pc), ep);
      chk(int'(new_mask) == em, "R4 new_mask", int'(new_mask), em);
    end
    @(posedge clk); @(negedge clk);
    instr_done = 1'b0;
    #1;
    chk(save_ctx == et, "R10 save_ctx", int'(save_ctx), int'(et));
    chk(inhibit == et, "R8 inhibit set", int'(inhibit), int'(et));
    first_done = 1'b1;
    @(posedge clk); @(negedge clk);
    first_done = 1'b0;
    #1 chk(inhibit == 1'b0, "R8 inhibit cleared", int'(inhibit), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(take_trap == 1'b0 && inhibit == 1'b0 && save_ctx == 1'b0, "R11 reset outputs",
        int'({take_trap, inhibit, save_ctx}), 0);
    rst_n = 1'b1;
    instr_done = 1'b1;
    #1 chk(take_trap == 1'b0, "R11 nothing pending after reset", int'(take_trap), 0);
    instr_done = 1'b0;

    // R1 R2 R4 R5: each line against each mask
    for (int l = 0; l < 16; l++)
      for (int m = 0; m < 16; m++) run_case(16'(1) << l, 1'b0, 1'b0, m);
    // R1 R2: every pair of lines against every mask
    for (int a = 0; a < 16; a++)
      for (int b = a + 1; b < 16; b++)
        for (int m = 0; m < 16; m++) run_case((16'(1) << a) | (16'(1) << b), 1'b0, 1'b0, m);
    // R7: illegal opcode against each line and mask, and alone
    for (int l = 0; l < 17; l++)
      for (int m = 0; m < 16; m++)
        run_case((l < 16) ? (16'(1) << l) : 16'h0, 1'b0, 1'b1, m);
    // R6: non-maskable on mixed patterns
    for (int m = 0; m < 16; m++) begin
      run_case(16'h0000, 1'b1, 1'b0, m);
      run_case(16'hFFFF, 1'b1, 1'b1, m);
      run_case(16'h0001, 1'b1, 1'b0, m);
    end
    run_case(16'hA5C0, 1'b0, 1'b0, 9);
    run_case(16'hA5C0, 1'b0, 1'b0, 5);

    // R8: held off through a second boundary until first_done
    @(negedge clk);
    irq_req = 16'h0010; cur_mask = 4'd15; sample_en = 1'b1;
    @(posedge clk); @(negedge clk);
    sample_en = 1'b0; instr_done = 1'b1;
    #1 chk(take_trap == 1'b1, "R8 initial grant", int'(take_trap), 1);
    @(posedge clk); @(negedge clk);
    nmi_req = 1'b1; sample_en = 1'b1;
    #1 chk(take_trap == 1'b0, "R8 no grant while inhibited", int'(take_trap), 0);
    @(posedge clk); @(negedge clk);
    sample_en = 1'b0;
    #1 chk(take_trap == 1'b0, "R8 NMI also held off", int'(take_trap), 0);
    instr_done = 1'b0; first_done = 1'b1;
    @(posedge clk); @(negedge clk);
    first_done = 1'b0; instr_done = 1'b1;
    #1 chk(take_trap == 1'b1 && trap_kind == 2'd1, "R8 grant resumes after first_done",
           int'({take_trap, trap_kind}), 5);
    @(posedge clk); @(negedge clk);
    instr_done = 1'b0; first_done = 1'b1; nmi_req = 1'b0;
    @(posedge clk); @(negedge clk);
    first_done = 1'b0;

    // R9: lines change with the window closed
    irq_req = 16'h0020; sample_en = 1'b1; cur_mask = 4'd15;
    @(posedge clk); @(negedge clk);
    sample_en = 1'b0; irq_req = 16'h0008; nmi_req = 1'b1;
    @(posedge clk); @(negedge clk);
    instr_done = 1'b1;
    #1 chk(take_trap == 1'b1 && trap_kind == 2'd0 && trap_level == 4'd5,
           "R9 snapshot held outside window", int'(trap_level), 5);
    @(posedge clk); @(negedge clk);
    instr_done = 1'b0; first_done = 1'b1; sample_en = 1'b1;
    @(posedge clk); @(negedge clk);
    first_done = 1'b0; sample_en = 1'b0; instr_done = 1'b1;
    #1 chk(take_trap == 1'b1 && trap_kind == 2'd1, "R9 new capture in window",
           int'(trap_kind), 1);
    @(negedge clk);
    instr_done = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule